// File: doc/BRIEF.md
# Dual-Read Register File with Address Pointer Pair

This block is the general-purpose register store of a small single-issue RISC core. It holds thirty-two 8-bit registers. Two read ports are combinational, so the two ALU operands for an instruction appear in the same cycle that their addresses are presented. One write port stores the ALU result at the next rising clock edge. Fetching both operands, computing and writing back therefore fit in a single cycle, and one ALU operation completes every cycle.

The two top registers, 30 (low byte) and 31 (high byte), are also presented together as a 16-bit pointer for indirect addressing. This pointer can be read as one word at any time. A single strobe adds one to it as a unit. The block only supplies the 16-bit value. Deciding whether that value selects registers, I/O or program memory is done outside the block.

Top module: `dual_read_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 32 registers to 0x00, so every read port and `ptr_value` show zero after that edge.
- R2: Both read ports return the register selected by their own address combinationally. The two addresses are independent and may be equal.
- R3: When `wr_en` is high at a rising edge, `wr_data` is stored in register `wr_addr`. When `wr_en` is low, no register changes through the write port.
- R4: A read port whose address equals `wr_addr` during a write cycle returns the value from before the write. The written value appears from the cycle after the edge.
- R5: `ptr_value` is always {register 31, register 30}. Ordinary writes to either register change the pointer word.
- R6: When `ptr_inc` is high at a rising edge, the 16-bit pair increases by one. A carry out of register 30 propagates into register 31.
- R7: Incrementing a pointer value of 0xFFFF gives 0x0000.
- R8: When `wr_en` targets register 30 or 31 in the same cycle as `ptr_inc`, the targeted byte takes `wr_data`. The other byte of the pair takes its incremented value, computed from the pair as it stood before the edge.
- R9: A pointer increment changes no register other than 30 and 31.
- R10: With `wr_en` and `ptr_inc` both low, the register contents and `ptr_value` stay the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 5 | First operand register index |
| rd_a_data | output | 8 | First operand value |
| rd_b_addr | input | 5 | Second operand register index |
| rd_b_data | output | 8 | Second operand value |
| wr_en | input | 1 | Write strobe for the result port |
| wr_addr | input | 5 | Result register index |
| wr_data | input | 8 | Result value |
| ptr_inc | input | 1 | Add one to the 16-bit pointer pair |
| ptr_value | output | 16 | Pointer word {reg31, reg30} |

## Verification
The assertions check the following on every cycle:
- a write lands at its address one edge later;
- a reset leaves the whole array clear;
- an unobstructed increment adds exactly one to the pointer word, including the 0xFFFF wrap;
- a write to the low pointer byte wins over a coincident increment;
- the pointer does not move when neither strobe is active;
- an increment leaves the register below the pair alone.

Several behaviours can only be shown by the bench scenarios. These are the old-value return for a same-cycle read and write, independent addressing on the two read ports, the carry into a high byte that is being overwritten, and the increment of a high byte while the low byte is being written.

// File: rtl/rf_ptr_pkg.sv
package rf_ptr_pkg;

  localparam int unsigned RF_WIDTH_DEF  = 8;
  localparam int unsigned RF_DEPTH_DEF  = 32;
  localparam int unsigned RF_PTR_LO_DEF = 30;

  // Add one to a value of 'bits' width held in a 32-bit container, wrapping.
  function automatic logic [31:0] pair_plus_one(input logic [31:0] cur,
                                                input int unsigned bits);
    logic [31:0] mask;
    if (bits >= 32) mask = '1;
    else            mask = (32'd1 << bits) - 32'd1;
    return (cur + 32'd1) & mask;
  endfunction

  // Carry out of the low byte when it is incremented: all ones.
  function automatic logic low_carry(input logic [31:0] lo, input int unsigned bits);
    logic [31:0] mask;
    if (bits >= 32) mask = '1;
    else            mask = (32'd1 << bits) - 32'd1;
    return (lo & mask) == mask;
  endfunction

endpackage

// File: rtl/gpr_read_mux.sv
module gpr_read_mux #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][W-1:0] regs,
  input  logic [AW-1:0]           addr,
  output logic [W-1:0]            data
);

  generate
    if (DEPTH == (1 << AW)) begin : g_full
      // Every address names a register.
      assign data = regs[addr];
    end else begin : g_partial
      // Addresses past the top register read as zero.
      logic in_range;
      assign in_range = ({1'b0, addr} < (AW+1)'(DEPTH));
      always_comb begin
        data = '0;
        if (in_range) data = regs[addr];
      end
    end
  endgenerate

endmodule

// File: rtl/ptr_step.sv
module ptr_step
  import rf_ptr_pkg::*;
#(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic [W-1:0] cur_lo,
  input  logic [W-1:0] cur_hi,
  output logic [W-1:0] nxt_lo,
  output logic [W-1:0] nxt_hi,
  output logic         lo_carry
);

  logic [PW-1:0] pair_cur;
  logic [PW-1:0] pair_nxt;

  assign pair_cur = {cur_hi, cur_lo};
  assign pair_nxt = PW'(pair_plus_one(32'(pair_cur), PW));
  assign nxt_lo   = pair_nxt[W-1:0];
  assign nxt_hi   = pair_nxt[PW-1:W];
  assign lo_carry = low_carry(32'(cur_lo), W);

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned W      = 8,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned PTR_LO = 30,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PTR_HI = PTR_LO + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [W-1:0]            wr_data,
  input  logic                    inc_en,
  input  logic [W-1:0]            inc_lo,
  input  logic [W-1:0]            inc_hi,
  output logic [DEPTH-1:0][W-1:0] regs_q
);

  // Named events for the pointer pair.
  logic wr_hit_lo, wr_hit_hi;
  logic inc_takes_lo, inc_takes_hi;

  assign wr_hit_lo    = wr_en && (wr_addr == AW'(PTR_LO));
  assign wr_hit_hi    = wr_en && (wr_addr == AW'(PTR_HI));
  assign inc_takes_lo = inc_en && !wr_hit_lo;
  assign inc_takes_hi = inc_en && !wr_hit_hi;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
      logic sel;
      assign sel = wr_en && (wr_addr == AW'(g));
      if (g == PTR_LO) begin : g_lo
        always_ff @(posedge clk) begin
          if (rst)               regs_q[g] <= '0;
          else if (sel)          regs_q[g] <= wr_data;
          else if (inc_takes_lo) regs_q[g] <= inc_lo;
        end
      end else if (g == PTR_HI) begin : g_hi
        always_ff @(posedge clk) begin
          if (rst)               regs_q[g] <= '0;
          else if (sel)          regs_q[g] <= wr_data;
          else if (inc_takes_hi) regs_q[g] <= inc_hi;
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (rst)      regs_q[g] <= '0;
          else if (sel) regs_q[g] <= wr_data;
        end
      end
    end
  endgenerate

  // ---------------- assertions ----------------
  logic rst_seen_q;
  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q) begin
      a_r1_reset_clear: assert (regs_q == '0);
    end
  end

  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> regs_q[$past(wr_addr)] == $past(wr_data));

  a_r9_inc_isolated: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !wr_en) |=> $stable(regs_q[PTR_LO-1]));

endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int unsigned W      = rf_ptr_pkg::RF_WIDTH_DEF,
  parameter int unsigned DEPTH  = rf_ptr_pkg::RF_DEPTH_DEF,
  parameter int unsigned PTR_LO = rf_ptr_pkg::RF_PTR_LO_DEF,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = 2 * W,
  localparam int unsigned PTR_HI = PTR_LO + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_addr,
  output logic [W-1:0]  rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [W-1:0]  rd_b_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          ptr_inc,
  output logic [PW-1:0] ptr_value
);

  logic [DEPTH-1:0][W-1:0] regs_q;
  logic [W-1:0]            inc_lo, inc_hi;
  logic                    lo_carry;
  logic                    wr_to_pair;

  ptr_step #(.W(W)) u_step (
    .cur_lo   (regs_q[PTR_LO]),
    .cur_hi   (regs_q[PTR_HI]),
    .nxt_lo   (inc_lo),
    .nxt_hi   (inc_hi),
    .lo_carry (lo_carry)
  );

  gpr_bank #(.W(W), .DEPTH(DEPTH), .PTR_LO(PTR_LO)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .inc_en  (ptr_inc),
    .inc_lo  (inc_lo),
    .inc_hi  (inc_hi),
    .regs_q  (regs_q)
  );

  // Two independent operand ports built from one mux description.
  logic [1:0][AW-1:0] rd_addr_v;
  logic [1:0][W-1:0]  rd_data_v;
  assign rd_addr_v = {rd_b_addr, rd_a_addr};

  generate
    for (genvar p = 0; p < 2; p++) begin : g_port
      gpr_read_mux #(.W(W), .DEPTH(DEPTH)) u_mux (
        .regs (regs_q),
        .addr (rd_addr_v[p]),
        .data (rd_data_v[p])
      );
    end
  endgenerate

  assign rd_a_data  = rd_data_v[0];
  assign rd_b_data  = rd_data_v[1];
  assign ptr_value  = {regs_q[PTR_HI], regs_q[PTR_LO]};
  assign wr_to_pair = wr_en && ((wr_addr == AW'(PTR_LO)) || (wr_addr == AW'(PTR_HI)));

  // ---------------- assertions ----------------
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && !wr_to_pair) |=> ptr_value == $past(ptr_value) + PW'(1));

  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && !wr_to_pair && (&ptr_value)) |=> ptr_value == '0);

  a_r8_write_wins_lo: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && wr_en && wr_addr == AW'(PTR_LO))
      |=> ptr_value[W-1:0] == $past(wr_data));

  a_r6_carry_moves_hi: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && !wr_to_pair && lo_carry)
      |=> ptr_value[PW-1:W] != $past(ptr_value[PW-1:W]));

  a_r10_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !ptr_inc) |=> $stable(ptr_value));

endmodule

// File: tb/dual_read_regfile_test.sv
`timescale 1ns/1ps
module dual_read_regfile_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] rd_a_addr, rd_b_addr, wr_addr;
  logic [7:0] rd_a_data, rd_b_data, wr_data;
  logic       wr_en, ptr_inc;
  logic [15:0] ptr_value;

  always #2.5 clk = ~clk;   // 200 MHz

  dual_read_regfile uut (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_inc(ptr_inc), .ptr_value(ptr_value)
  );

  typedef struct {
    string      req;
    logic [7:0] exp_a;
    logic [7:0] exp_b;
    logic [15:0] exp_ptr;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model [32];
  int         total = 0;
  int         bad   = 0;
  bit         done  = 0;

  // Driver: apply one cycle of stimulus, push the expected observation, advance the model.
  task automatic step(input string req, input bit do_rst,
                      input bit we, input logic [4:0] wa, input logic [7:0] wd,
                      input bit inc, input logic [4:0] ra, input logic [4:0] rb,
                      input bit check);
    exp_t e;
    logic [15:0] pair;
    @(negedge clk);
    rst = do_rst; wr_en = we; wr_addr = wa; wr_data = wd;
    ptr_inc = inc; rd_a_addr = ra; rd_b_addr = rb;
    if (check) begin
      e.req = req; e.exp_a = model[ra]; e.exp_b = model[rb];
      e.exp_ptr = {model[31], model[30]};
      sb_q.push_back(e);
    end
    @(posedge clk);
    if (do_rst) begin
      for (int i = 0; i < 32; i++) model[i] = 8'h00;
    end else begin
      pair = {model[31], model[30]};
      if (inc) begin
        pair = pair + 16'd1;
        model[30] = pair[7:0];
        model[31] = pair[15:8];
      end
      if (we) model[wa] = wd;
    end
  endtask

  // Monitor: compare the design's outputs with the oldest expectation.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (rd_a_data !== e.exp_a || rd_b_data !== e.exp_b || ptr_value !== e.exp_ptr) begin
          bad++;
          $display("FAIL %s: a=%h b=%h ptr=%h expected a=%h b=%h ptr=%h",
                   e.req, rd_a_data, rd_b_data, ptr_value, e.exp_a, e.exp_b, e.exp_ptr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'hxx;
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; ptr_inc = 0;
    rd_a_addr = 0; rd_b_addr = 0;
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    // R1: everything zero after reset
    step("R1", 0, 0, 0, 0, 0, 0, 31, 1);
    step("R1", 0, 0, 0, 0, 0, 17, 30, 1);
    // R3: fill some registers
    step("R3", 0, 1, 5'd3, 8'hA5, 0, 3, 4, 1);
    step("R3", 0, 1, 5'd4, 8'h3C, 0, 3, 4, 1);
    step("R3", 0, 1, 5'd29, 8'h81, 0, 3, 4, 1);
    // R2: independent and equal addresses
    step("R2", 0, 0, 0, 0, 0, 3, 4, 1);
    step("R2", 0, 0, 0, 0, 0, 4, 4, 1);
    step("R2", 0, 0, 0, 0, 0, 29, 3, 1);
    // R3: write strobe low leaves register 3 alone
    step("R3", 0, 0, 5'd3, 8'hFF, 0, 3, 0, 1);
    step("R3", 0, 0, 0, 0, 0, 3, 0, 1);
    // R4: same-cycle read of written register gives old value, then new
    step("R4", 0, 1, 5'd3, 8'h5E, 0, 3, 3, 1);
    step("R4", 0, 0, 0, 0, 0, 3, 3, 1);
    // R5: pointer assembled from registers 30 and 31
    step("R5", 0, 1, 5'd30, 8'hFF, 0, 30, 31, 1);
    step("R5", 0, 1, 5'd31, 8'h12, 0, 30, 31, 1);
    step("R5", 0, 0, 0, 0, 0, 30, 31, 1);
    // R6: increment with carry 0x12FF -> 0x1300; R9 watches 29 and 0
    step("R6", 0, 0, 0, 0, 1, 29, 0, 1);
    step("R9", 0, 0, 0, 0, 1, 29, 3, 1);
    step("R6", 0, 0, 0, 0, 0, 30, 31, 1);
    // R10: idle cycles hold everything
    step("R10", 0, 0, 0, 0, 0, 30, 29, 1);
    step("R10", 0, 0, 0, 0, 0, 31, 3, 1);
    // R7: wrap 0xFFFF -> 0x0000
    step("R7", 0, 1, 5'd30, 8'hFF, 0, 30, 31, 1);
    step("R7", 0, 1, 5'd31, 8'hFF, 0, 30, 31, 1);
    step("R7", 0, 0, 0, 0, 1, 30, 31, 1);
    step("R7", 0, 0, 0, 0, 0, 30, 31, 1);
    // R8: pointer 0x00FF; write low=0x40 with increment -> 0x0140
    step("R8", 0, 1, 5'd30, 8'hFF, 0, 30, 31, 1);
    step("R8", 0, 1, 5'd30, 8'h40, 1, 30, 31, 1);
    step("R8", 0, 0, 0, 0, 0, 30, 31, 1);
    // R8: write high=0x77 with increment from 0x0140 -> 0x7741
    step("R8", 0, 1, 5'd31, 8'h77, 1, 30, 31, 1);
    step("R8", 0, 0, 0, 0, 0, 30, 31, 1);
    // R9: plain write elsewhere during increment, both land
    step("R9", 0, 1, 5'd7, 8'hC3, 1, 7, 29, 1);
    step("R9", 0, 0, 0, 0, 0, 7, 29, 1);
    // R1: reset again clears written contents
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 7, 3, 1);
    step("R1", 0, 0, 0, 0, 0, 30, 31, 1);
    @(negedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule